// File: doc/BRIEF.md
# Tag-Steered Shadow Key Bus Router

This block sits between a host memory system and a set of shadow units that replay the host's instruction stream in lockstep. A shadow unit tracks a protection key for every address the host holds. A one-bit tag memory runs alongside main memory and marks the cells that hold an address. During an opcode fetch the shadow data bus carries the opcode from main memory, so every unit decodes the same instruction. On operand and execute cycles the tag picks the source. A tagged cell exchanges its key with key memory. An untagged cell delivers its plain value from main memory, so index values still reach the shadow registers.

Shadow writes to untagged cells are normally dropped. The one exception is a write that falls inside a stack window, given by a base and a limit: there the key is written to key memory as well, so that a pushed word keeps both its value and its key. The block also holds the host ready line low during the first fetch cycle until every lockstep unit has reported that its previous instruction is complete, or until a programmable wait limit is reached. Finally, it flags any shadow arithmetic on a tagged operand other than adding or subtracting an untagged integer.

Top module: `key_bus_router`

## Requirements
- R1: While `cyc_fetch` is 1, `shadow_rdata` equals `main_rdata` and `key_we` is 0, whatever the tag, read and write inputs are.
- R2: Outside fetch, with `cyc_rd`=1 and `tag_bit`=1, `shadow_rdata` equals `key_rdata`. In every other case it equals `main_rdata`.
- R3: Outside fetch, with `cyc_wr`=1 and `tag_bit`=1, `key_we` is 1 and `key_wdata` equals `shadow_wdata`.
- R4: Outside fetch, with `cyc_wr`=1 and `tag_bit`=0, `key_we` is 1 only when `stk_base` <= `addr` <= `stk_limit` (unsigned, both ends inclusive). `key_we` is 0 whenever `cyc_wr`=0.
- R5: `host_ready` is 1 whenever `cyc_fetch` is 0. During fetch it is 1 once every bit of `unit_done` has been seen high since the last completed fetch, counting the current cycle. A fetch completes in a cycle with `cyc_fetch`=1 and `host_ready`=1. That cycle clears the record of done bits and the wait count.
- R6: During fetch, `host_ready` is also 1 once the number of earlier cycles of the same fetch with ready low reaches `max_wait`. With `max_wait`=0 there is no wait state.
- R7: One cycle after `alu_valid`=1, `invalid_op` is 1 exactly when a tagged operand was used by a non add/subtract operation (`alu_addsub`=0 with `alu_tag_a` or `alu_tag_b` set), or when both operands were tagged. Otherwise it is 0.
- R8: After reset, `invalid_op` is 0, the done record is empty and the wait count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_fetch | input | 1 | Current cycle is the first opcode fetch |
| cyc_rd | input | 1 | Shadow read cycle |
| cyc_wr | input | 1 | Shadow write cycle |
| addr | input | AW | Host address of the current cycle |
| tag_bit | input | 1 | Tag memory bit of the addressed cell (1 = holds an address) |
| main_rdata | input | DW | Main memory read data |
| key_rdata | input | DW | Key memory read data |
| shadow_wdata | input | DW | Data driven by the shadow unit on writes |
| shadow_rdata | output | DW | Data delivered to the shadow unit |
| key_wdata | output | DW | Key memory write data |
| key_we | output | 1 | Key memory write enable |
| stk_base | input | AW | Lowest address of the stack window |
| stk_limit | input | AW | Highest address of the stack window |
| unit_done | input | NU | Per-unit completion pulse of the previous instruction |
| max_wait | input | CW | Maximum wait states per fetch |
| host_ready | output | 1 | Ready line to the host memory cycle |
| alu_valid | input | 1 | Shadow arithmetic operation this cycle |
| alu_addsub | input | 1 | The operation is an add or subtract |
| alu_tag_a | input | 1 | First operand is tagged |
| alu_tag_b | input | 1 | Second operand is tagged |
| invalid_op | output | 1 | Illegal arithmetic on an address, one cycle later |

## Verification
The routing paths have no state, so a wrong select shows on `shadow_rdata` or `key_we` in the same cycle. The wait logic is where corrupted state would hide. If the done record is not cleared, the next fetch is released too early. If the wait count is not cleared, or is cleared too early, ready goes high a cycle early or late. Both show on `host_ready` within the first fetch after the fault. A fault in the operand check shows on `invalid_op` one cycle after the operation.

// File: rtl/key_bus_router.sv
module key_bus_router #(
  parameter int DW = 8,
  parameter int AW = 16,
  parameter int NU = 2,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_fetch,
  input  logic          cyc_rd,
  input  logic          cyc_wr,
  input  logic [AW-1:0] addr,
  input  logic          tag_bit,
  input  logic [DW-1:0] main_rdata,
  input  logic [DW-1:0] key_rdata,
  input  logic [DW-1:0] shadow_wdata,
  output logic [DW-1:0] shadow_rdata,
  output logic [DW-1:0] key_wdata,
  output logic          key_we,
  input  logic [AW-1:0] stk_base,
  input  logic [AW-1:0] stk_limit,
  input  logic [NU-1:0] unit_done,
  input  logic [CW-1:0] max_wait,
  output logic          host_ready,
  input  logic          alu_valid,
  input  logic          alu_addsub,
  input  logic          alu_tag_a,
  input  logic          alu_tag_b,
  output logic          invalid_op
);

  logic [NU-1:0] seen;
  logic [CW-1:0] wcnt;
  logic          in_stack, all_done, timed_out, bad_op;

  assign in_stack     = (addr >= stk_base) && (addr <= stk_limit);
  assign shadow_rdata = (!cyc_fetch && cyc_rd && tag_bit) ? key_rdata : main_rdata;
  assign key_we       = !cyc_fetch && cyc_wr && (tag_bit || in_stack);
  assign key_wdata    = shadow_wdata;

  assign all_done   = &(seen | unit_done);
  assign timed_out  = wcnt >= max_wait;
  assign host_ready = !cyc_fetch || all_done || timed_out;

  assign bad_op = alu_valid &&
                  ((!alu_addsub && (alu_tag_a || alu_tag_b)) || (alu_tag_a && alu_tag_b));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen       <= '0;
      wcnt       <= '0;
      invalid_op <= 1'b0;
    end else begin
      invalid_op <= bad_op;
      if (cyc_fetch && host_ready) begin
        seen <= '0;
        wcnt <= '0;
      end else begin
        seen <= seen | unit_done;
        if (cyc_fetch) wcnt <= wcnt + 1'b1;
      end
    end
  end

  p_fetch_no_key_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_fetch |-> !key_we);
  p_ready_outside_fetch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_fetch |-> host_ready);
  p_release_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_fetch && host_ready) |=> (wcnt == '0) && (seen == '0));
  p_wait_counts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_fetch && !host_ready) |=> (wcnt == $past(wcnt) + 1'b1));
  p_invalid_needs_op_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(invalid_op) |-> $past(alu_valid));
  p_no_write_without_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_wr |-> !key_we);

endmodule

// File: tb/sim_key_bus_router.sv
module sim_key_bus_router;
  localparam int DW = 8, AW = 16, NU = 2, CW = 8;

  logic clk = 0, rst_n = 0;
  logic cyc_fetch = 0, cyc_rd = 0, cyc_wr = 0, tag_bit = 0;
  logic [AW-1:0] addr = 0, stk_base = 16'h0100, stk_limit = 16'h011F;
  logic [DW-1:0] main_rdata = 0, key_rdata = 0, shadow_wdata = 0;
  logic [DW-1:0] shadow_rdata, key_wdata;
  logic key_we, host_ready, invalid_op;
  logic [NU-1:0] unit_done = 0;
  logic [CW-1:0] max_wait = 5;
  logic alu_valid = 0, alu_addsub = 0, alu_tag_a = 0, alu_tag_b = 0;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [NU-1:0] m_seen;
  int m_cnt;
  logic exp_inv;

  key_bus_router #(.DW(DW), .AW(AW), .NU(NU), .CW(CW)) u0 (.*);

  always #10 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic f_inv(logic v, logic as, logic a, logic b);
    return v && ((!as && (a || b)) || (a && b));
  endfunction

  function automatic logic f_ready(logic f, logic [NU-1:0] s, logic [NU-1:0] d, int c, int mw);
    return !f || (&(s | d)) || (c >= mw);
  endfunction

  task automatic check_now();
    logic [DW-1:0] er;
    logic ew;
    #1;
    er = (!cyc_fetch && cyc_rd && tag_bit) ? key_rdata : main_rdata;
    ew = !cyc_fetch && cyc_wr && (tag_bit || (addr >= stk_base && addr <= stk_limit));
    if (cyc_fetch) begin
      chk("R1 fetch data", shadow_rdata, main_rdata);
      chk("R1 fetch no write", key_we, 0);
    end else begin
      chk("R2 read route", shadow_rdata, er);
      chk(tag_bit ? "R3 tagged write" : "R4 stack write", key_we, ew);
      if (ew) chk("R3 key data", key_wdata, shadow_wdata);
    end
    chk("R5 R6 ready", host_ready, f_ready(cyc_fetch, m_seen, unit_done, m_cnt, max_wait));
    exp_inv = f_inv(alu_valid, alu_addsub, alu_tag_a, alu_tag_b);
    @(posedge clk);
    if (cyc_fetch && f_ready(cyc_fetch, m_seen, unit_done, m_cnt, max_wait)) begin
      m_seen = 0; m_cnt = 0;
    end else begin
      m_seen = m_seen | unit_done;
      if (cyc_fetch) m_cnt++;
    end
    @(negedge clk);
    chk("R7 invalid", invalid_op, exp_inv);
  endtask

  task automatic rnd();
    cyc_fetch    = ($urandom % 3) == 0;
    cyc_rd       = $urandom % 2;
    cyc_wr       = !cyc_rd && ($urandom % 2);
    tag_bit      = $urandom % 2;
    addr         = 16'h00F0 + ($urandom % 64);
    main_rdata   = $urandom;
    key_rdata    = $urandom;
    shadow_wdata = $urandom;
    unit_done    = {($urandom % 4) == 0, ($urandom % 4) == 0};
    alu_valid    = $urandom % 2;
    alu_addsub   = $urandom % 2;
    alu_tag_a    = $urandom % 2;
    alu_tag_b    = $urandom % 2;
  endtask

  initial begin
    void'($urandom(32'd1234));
    m_seen = 0; m_cnt = 0;
    cyc_fetch = 1;
    repeat (3) @(negedge clk);
    #1;
    chk("R8 reset invalid", invalid_op, 0);
    chk("R8 reset ready", host_ready, 0);
    rst_n = 1;
    @(negedge clk);
    cyc_fetch = 0;
    // stack window edges
    cyc_wr = 1; tag_bit = 0;
    addr = 16'h0100; check_now();
    addr = 16'h011F; check_now();
    addr = 16'h0120; check_now();
    addr = 16'h00FF; check_now();
    cyc_wr = 0; addr = 16'h0110; check_now();
    // fetch ignores tag and write
    cyc_fetch = 1; cyc_wr = 1; tag_bit = 1; unit_done = 2'b11; check_now();
    // timeout path: max_wait 3, no done
    cyc_wr = 0; unit_done = 0; max_wait = 3;
    repeat (5) check_now();
    max_wait = 0; check_now();
    // invalid operand cases
    cyc_fetch = 0; alu_valid = 1;
    alu_addsub = 1; alu_tag_a = 1; alu_tag_b = 0; check_now();
    alu_addsub = 1; alu_tag_a = 1; alu_tag_b = 1; check_now();
    alu_addsub = 0; alu_tag_a = 0; alu_tag_b = 1; check_now();
    alu_addsub = 0; alu_tag_a = 0; alu_tag_b = 0; check_now();
    for (int i = 0; i < 3000; i++) begin
      rnd();
      max_wait = (i % 500 == 0) ? 0 : 7;
      check_now();
    end
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule